// File: doc/BRIEF.md
# INTx Request Handshake Controller

This block sits on the application side of a PCI Express endpoint. It turns internal interrupt events into a legacy INTx request toward the endpoint's configuration interface. It drives a request line and a pending line. It watches a one-clock acknowledge pulse coming back from the endpoint. It also takes a "serviced" indication from host-side software, for example the output of a write-one-to-clear register decode.

Each interrupt runs as a two-phase handshake:

1. Request and pending rise together.
2. The first acknowledge confirms that the assert message has gone out.
3. The request is held until the host reports service.
4. Dropping the request causes the endpoint to emit the deassert message, which completes with a second acknowledge.

A new request is launched only while the function status reports INTx enabled. The endpoint does not block requests on its own when the disable bit is set. Events that arrive while a handshake is running, or while INTx is disabled, fold into a single sticky flag. That flag is issued as one follow-up request once the controller is idle and enabled.

Top module: `intx_req_ctrl`

## Requirements
- R1: While `rst_ni` is low, `req_o`, `pend_o` and `busy_o` are all low, and the controller returns to idle.
- R2: In idle with INTx enabled, an event is followed one clock later by `req_o`, `pend_o` and `busy_o` rising together.
- R3: INTx is disabled when `fn_status_i[INTX_DIS_BIT]` (default bit 10) is 1. While it is disabled, no request is launched. The event is held and launched one clock after the bit returns to 0. The other status bits have no effect.
- R4: After the first acknowledge, if no service has been reported, `req_o` and `pend_o` stay high until `serviced_i` is seen.
- R5: A `serviced_i` pulse seen before the first acknowledge is remembered. `req_o` and `pend_o` then fall one clock after that acknowledge.
- R6: A `serviced_i` pulse seen after the first acknowledge makes `req_o` and `pend_o` fall one clock later, while `busy_o` stays high.
- R7: `busy_o` stays high from the launch until the second acknowledge, and falls one clock after that acknowledge.
- R8: `ack_i` and `serviced_i` in idle have no effect. A service pulse given in idle is not carried into the next request.
- R9: Any number of events during a handshake produce exactly one follow-up request, launched one clock after the controller returns to idle.
- R10: Any bit of `event_i` starts a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | NUM_SRC | Interrupt event sources, one clock per event |
| fn_status_i | input | STAT_W | Function status vector; bit INTX_DIS_BIT set means INTx disabled |
| ack_i | input | 1 | One-clock acknowledge from the endpoint (assert, then deassert) |
| serviced_i | input | 1 | One-clock indication that host software has serviced the interrupt |
| req_o | output | 1 | INTx request line toward the endpoint |
| pend_o | output | 1 | Interrupt pending line toward the endpoint |
| busy_o | output | 1 | High from launch until the second acknowledge |

## Verification
The bench builds the block with its defaults: four event sources and a 16-bit status vector with the disable flag at bit 10. At that size every source can be combined with every placement of the service pulse. Those placements run from two clocks before the first acknowledge to three clocks after it, so the remembered-service path, the same-cycle path and the held-request path are all swept. Each non-disable status bit is also set on its own to show that it does not gate a launch. The sweep also covers burst events during a handshake, ignored stimulus in idle, and reset in the middle of a handshake.

// File: rtl/intx_pkg.sv
package intx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_ACK1 = 2'd1,
    ST_WAIT_SVC  = 2'd2,
    ST_WAIT_ACK2 = 2'd3
  } intx_state_e;
endpackage

// File: rtl/intx_event_latch.sv
module intx_event_latch #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] event_i,
  input  logic               take_i,
  output logic               want_o
);
  logic ev_any;
  logic sticky_q;

  assign ev_any = |event_i;
  assign want_o = ev_any | sticky_q;

  // events not consumed by a launch in the same cycle collapse into one flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sticky_q <= 1'b0;
    else if (take_i) sticky_q <= 1'b0;
    else if (ev_any) sticky_q <= 1'b1;
  end
endmodule

// File: rtl/intx_hs_fsm.sv
module intx_hs_fsm
  import intx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_i,
  input  logic enable_i,
  input  logic ack_i,
  input  logic serviced_i,
  output logic take_o,
  output logic req_o,
  output logic pend_o,
  output logic busy_o
);
  intx_state_e state_q, state_d;
  logic svc_seen_q, svc_seen_d;

  assign take_o = (state_q == ST_IDLE) && want_i && enable_i;

  always_comb begin
    state_d    = state_q;
    svc_seen_d = svc_seen_q;
    unique case (state_q)
      ST_IDLE: begin
        svc_seen_d = 1'b0;
        if (take_o) state_d = ST_WAIT_ACK1;
      end
      ST_WAIT_ACK1: begin
        if (ack_i) begin
          state_d    = (svc_seen_q || serviced_i) ? ST_WAIT_ACK2 : ST_WAIT_SVC;
          svc_seen_d = 1'b0;
        end else if (serviced_i) begin
          svc_seen_d = 1'b1;
        end
      end
      ST_WAIT_SVC: begin
        if (serviced_i) state_d = ST_WAIT_ACK2;
      end
      ST_WAIT_ACK2: begin
        if (ack_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      svc_seen_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      svc_seen_q <= svc_seen_d;
    end
  end

  assign req_o  = (state_q == ST_WAIT_ACK1) || (state_q == ST_WAIT_SVC);
  assign pend_o = req_o;
  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/intx_req_ctrl.sv
module intx_req_ctrl #(
  parameter int NUM_SRC      = 4,
  parameter int STAT_W       = 16,
  parameter int INTX_DIS_BIT = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] event_i,
  input  logic [STAT_W-1:0]  fn_status_i,
  input  logic               ack_i,
  input  logic               serviced_i,
  output logic               req_o,
  output logic               pend_o,
  output logic               busy_o
);
  logic want, take, intx_en;
  logic status_unused;

  assign intx_en       = ~fn_status_i[INTX_DIS_BIT];
  assign status_unused = ^fn_status_i;

  intx_event_latch #(.NUM_SRC(NUM_SRC)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .event_i(event_i),
    .take_i (take),
    .want_o (want)
  );

  intx_hs_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .want_i    (want),
    .enable_i  (intx_en),
    .ack_i     (ack_i),
    .serviced_i(serviced_i),
    .take_o    (take),
    .req_o     (req_o),
    .pend_o    (pend_o),
    .busy_o    (busy_o)
  );
endmodule

// File: rtl/intx_req_ctrl_chk.sv
module intx_req_ctrl_chk #(
  parameter int STAT_W       = 16,
  parameter int INTX_DIS_BIT = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [STAT_W-1:0] fn_status_i,
  input logic              ack_i,
  input logic              req_o,
  input logic              pend_o,
  input logic              busy_o
);
  assert_launch_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> !$past(fn_status_i[INTX_DIS_BIT]));

  assert_launch_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $rose(busy_o) && pend_o);

  assert_pend_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> pend_o);

  assert_drop_keeps_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o) |-> busy_o);

  assert_busy_end_on_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(ack_i) && !$past(req_o));

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !req_o && !pend_o);
endmodule

bind intx_req_ctrl intx_req_ctrl_chk #(
  .STAT_W(STAT_W),
  .INTX_DIS_BIT(INTX_DIS_BIT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fn_status_i(fn_status_i),
  .ack_i      (ack_i),
  .req_o      (req_o),
  .pend_o     (pend_o),
  .busy_o     (busy_o)
);

// File: tb/sim_intx_req_ctrl.sv
module sim_intx_req_ctrl;
  localparam int NUM_SRC = 4;
  localparam int STAT_W  = 16;
  localparam int DIS_BIT = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NUM_SRC-1:0] event_i = '0;
  logic [STAT_W-1:0]  fn_status_i = '0;
  logic ack_i = 1'b0;
  logic serviced_i = 1'b0;
  logic req_o, pend_o, busy_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  intx_req_ctrl #(.NUM_SRC(NUM_SRC), .STAT_W(STAT_W), .INTX_DIS_BIT(DIS_BIT)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .event_i(event_i), .fn_status_i(fn_status_i),
    .ack_i(ack_i), .serviced_i(serviced_i), .req_o(req_o), .pend_o(pend_o), .busy_o(busy_o)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic chk_all(input logic r, input logic p, input logic b, input string tag);
    chk(req_o, r, tag);
    chk(pend_o, p, tag);
    chk(busy_o, b, tag);
  endtask

  // finish a running handshake from WAIT_ACK1
  task automatic finish_hs();
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    chk_all(1'b1, 1'b1, 1'b1, "R4 held after ack1");
    serviced_i = 1'b1; tick(); serviced_i = 1'b0;
    chk_all(1'b0, 1'b0, 1'b1, "R6 drop on service");
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    chk_all(1'b0, 1'b0, 1'b0, "R7 end on ack2");
  endtask

  task automatic run_case(input int src, input int off);
    int a, s, d, b;
    string tag;
    a = 3;
    s = a + off;
    d = (s > a) ? s : a;
    b = d + 2;
    event_i = NUM_SRC'(1) << src; tick(); event_i = '0;
    chk_all(1'b1, 1'b1, 1'b1, "R2/R10 launch");
    for (int c = 1; c <= b + 2; c++) begin
      ack_i      = (c == a) || (c == b);
      serviced_i = (c == s);
      tick();
      ack_i = 1'b0; serviced_i = 1'b0;
      if (s > a && c >= a && c < s) tag = "R4 held";
      else if (s < a)               tag = "R5 early service";
      else                          tag = "R6 service";
      chk(req_o, c < d, tag);
      chk(pend_o, c < d, tag);
      chk(busy_o, c < b, "R7 busy window");
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk_all(1'b0, 1'b0, 1'b0, "R1 reset");
    rst_ni = 1'b1;
    tick();
    chk_all(1'b0, 1'b0, 1'b0, "R1 after release");

    // R5/R6/R4/R7/R10 sweep: every source x service placement
    for (int src = 0; src < NUM_SRC; src++)
      for (int off = -2; off <= 3; off++)
        run_case(src, off);

    // R3: disable blocks, event held and launched on enable
    fn_status_i[DIS_BIT] = 1'b1;
    event_i = 4'b0010; tick(); event_i = '0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk_all(1'b0, 1'b0, 1'b0, "R3 blocked");
    end
    fn_status_i[DIS_BIT] = 1'b0; tick();
    chk_all(1'b1, 1'b1, 1'b1, "R3 launch on enable");
    finish_hs();
    tick();
    chk(busy_o, 1'b0, "R3 single launch");

    // R3: other status bits do not gate
    for (int bt = 0; bt < STAT_W; bt++) begin
      if (bt != DIS_BIT) begin
        fn_status_i = STAT_W'(1) << bt;
        event_i = 4'b0001; tick(); event_i = '0;
        chk(req_o, 1'b1, "R3 other bit no effect");
        finish_hs();
      end
    end
    fn_status_i = '0;

    // R8: idle ack/service ignored and not remembered
    ack_i = 1'b1; serviced_i = 1'b1; tick(); ack_i = 1'b0; serviced_i = 1'b0;
    chk_all(1'b0, 1'b0, 1'b0, "R8 idle stimulus");
    tick();
    chk_all(1'b0, 1'b0, 1'b0, "R8 idle stimulus");
    event_i = 4'b1000; tick(); event_i = '0;
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    chk(req_o, 1'b1, "R8 idle service not carried");
    serviced_i = 1'b1; tick(); serviced_i = 1'b0;
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    chk(busy_o, 1'b0, "R8 cleanup");

    // R9: burst of events during handshake -> one follow-up
    event_i = 4'b0100; tick(); event_i = 4'b0001;
    tick(); event_i = 4'b1010;
    ack_i = 1'b1; tick(); ack_i = 1'b0; event_i = 4'b0001;
    serviced_i = 1'b1; tick(); serviced_i = 1'b0; event_i = '0;
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    chk(busy_o, 1'b0, "R9 idle gap");
    tick();
    chk_all(1'b1, 1'b1, 1'b1, "R9 follow-up");
    finish_hs();
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(busy_o, 1'b0, "R9 only one follow-up");
    end

    // R1: reset mid-handshake
    event_i = 4'b0001; tick(); event_i = '0;
    #1 rst_ni = 1'b0;
    #1 chk_all(1'b0, 1'b0, 1'b0, "R1 mid reset");
    tick(); rst_ni = 1'b1;
    tick();
    chk_all(1'b0, 1'b0, 1'b0, "R1 idle after reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule